// File: doc/BRIEF.md
# Zero-Address Stack Machine Core

This block is a small processor that keeps its operands on a push-down stack inside the core, not in named registers. A program is a byte stream fetched from a byte-addressed memory under a program counter. Two instruction forms exist. A memory instruction is four bytes long: an opcode byte followed by a 24-bit address, most significant byte first. It either loads a 32-bit word onto the stack or stores the top word to memory. An arithmetic instruction is a single opcode byte that names no operand. It consumes the top two stack entries and leaves its result on top.

All memory traffic goes through one request channel with valid/ready flow control. When the core raises `mem_req_valid` it holds address, direction, size and write data steady until a cycle with `mem_req_ready` high accepts them. Each accepted read returns exactly one response on `mem_rsp_valid`, no earlier than the cycle after acceptance. The core has no ready on the response side, so the memory may present the response whenever it has it. Writes get no response. Instruction bytes are read one at a time, with the byte in the low eight bits of the response. Data accesses move whole 32-bit words.

The stack holds 16 words. A load while the stack is full, or an instruction that needs more entries than the stack holds, raises a sticky fault and stops the core without touching memory. A dedicated stop opcode halts the core cleanly.

Top module: `smc_core`

## Requirements
- R1: After reset the core requests a byte read at address 0 in the first cycle, with `halted` and `fault` low. Reset also clears an earlier fault or halt.
- R2: Opcodes are 0x20 load, 0x21 store, 0x30 add, 0x31 subtract, 0x32 multiply and 0xFF stop. Load and store take four fetched bytes: the opcode, then address bits 23:16, 15:8 and 7:0. All others take one byte. The program counter advances by the instruction length, so each instruction byte is fetched exactly once.
- R3: A load issues one word read at its address and pushes the returned `mem_rsp_data` onto the stack.
- R4: A store issues one word write of the top entry to its address and removes that entry, so stores return loaded words in reverse order at every depth from 1 to 16.
- R5: Add replaces the top two entries with their sum modulo 2^32.
- R6: Subtract replaces the top two entries with the second entry minus the top entry, modulo 2^32.
- R7: Multiply replaces the top two entries with the low 32 bits of their product.
- R8: A load executed with 16 entries on the stack issues no memory read, sets `fault` and halts. Sixteen loads in a row succeed.
- R9: A store on an empty stack, or an arithmetic instruction with fewer than two entries, issues no memory write, sets `fault` and halts.
- R10: The stop opcode sets `halted` with `fault` low. Any opcode not listed in R2 sets `fault` and halts. A halted core issues no further requests.
- R11: A request not yet accepted keeps valid, address, direction, size and write data unchanged into the next cycle. Every accepted read gets exactly one response.
- R12: `halted` and `fault` stay set until reset, and `fault` is only ever set together with `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = word write, 0 = read |
| mem_req_word | output | 1 | 1 = 32-bit data access, 0 = instruction byte read |
| mem_req_addr | output | 24 | Byte address of the access |
| mem_req_wdata | output | 32 | Word to write (the stack top) |
| mem_rsp_valid | input | 1 | Read response present (one cycle per accepted read) |
| mem_rsp_data | input | 32 | Read data; a fetched byte is in bits 7:0 |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Sticky stack or opcode fault |

## Verification
The stack-limit test and the memory access it guards are decided in the same execute cycle. There the core either moves on to the word request or halts with a fault, and one wrong comparison lets a request slip out. This is provoked with a seventeenth load, a store on an empty stack, and a subtract with a single entry. The bench memory counts the word reads and writes that actually reach it, and it confirms that the target word is unchanged. It also counts the instruction bytes fetched, which must stop exactly at the faulting opcode's length. Back-pressure is mixed in by pseudo-randomly withholding `mem_req_ready` on alternate runs, and every stalled request is compared against its value one cycle later.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  localparam logic [7:0] OPC_PUSH = 8'h20;
  localparam logic [7:0] OPC_POP  = 8'h21;
  localparam logic [7:0] OPC_ADD  = 8'h30;
  localparam logic [7:0] OPC_SUB  = 8'h31;
  localparam logic [7:0] OPC_MUL  = 8'h32;
  localparam logic [7:0] OPC_HALT = 8'hFF;

  typedef enum logic [2:0] {K_PUSH, K_POP, K_ALU, K_HALT, K_BAD} kind_t;
  typedef enum logic [1:0] {A_ADD, A_SUB, A_MUL} alu_t;
  typedef enum logic [2:0] {S_IREQ, S_IWAIT, S_EXEC, S_DREQ, S_DWAIT, S_HALT} state_t;
  typedef enum logic [1:0] {SO_NONE, SO_PUSH, SO_POP, SO_FOLD} stk_op_t;
endpackage

// File: rtl/smc_decode.sv
`timescale 1ns/1ps
module smc_decode
  import smc_pkg::*;
(
  input  logic [7:0] opc,
  output kind_t      kind,
  output alu_t       alu_sel,
  output logic       long_form,
  output logic [1:0] need
);
  always_comb begin
    kind    = K_BAD;
    alu_sel = A_ADD;
    need    = 2'd0;
    case (opc)
      OPC_PUSH: kind = K_PUSH;
      OPC_POP:  begin kind = K_POP; need = 2'd1; end
      OPC_ADD:  begin kind = K_ALU; alu_sel = A_ADD; need = 2'd2; end
      OPC_SUB:  begin kind = K_ALU; alu_sel = A_SUB; need = 2'd2; end
      OPC_MUL:  begin kind = K_ALU; alu_sel = A_MUL; need = 2'd2; end
      OPC_HALT: kind = K_HALT;
      default:  kind = K_BAD;
    endcase
    long_form = (kind == K_PUSH) || (kind == K_POP);
  end
endmodule

// File: rtl/smc_alu.sv
`timescale 1ns/1ps
module smc_alu
  import smc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  alu_t         sel,
  output logic [W-1:0] res
);
  always_comb begin
    case (sel)
      A_SUB:   res = lhs - rhs;
      A_MUL:   res = lhs * rhs;
      default: res = lhs + rhs;
    endcase
  end
endmodule

// File: rtl/smc_stack.sv
`timescale 1ns/1ps
module smc_stack
  import smc_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  stk_op_t                    op,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               top,
  output logic [W-1:0]               second,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot [DEPTH];
  logic [CW-1:0] cnt_m1, cnt_m2;
  logic [IW-1:0] top_idx, sec_idx, new_idx;

  assign cnt_m1  = count - CW'(1);
  assign cnt_m2  = count - CW'(2);
  assign top_idx = cnt_m1[IW-1:0];
  assign sec_idx = cnt_m2[IW-1:0];
  assign new_idx = count[IW-1:0];
  assign top     = slot[top_idx];
  assign second  = slot[sec_idx];
  assign full    = (count == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case (op)
        SO_PUSH: count <= count + CW'(1);
        SO_POP:  count <= cnt_m1;
        SO_FOLD: count <= cnt_m1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == SO_PUSH) slot[new_idx] <= wdata;
    else if (op == SO_FOLD) slot[sec_idx] <= wdata;
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SO_PUSH) |-> !full);
  a_r9_no_underflow_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SO_POP) |-> (count != '0));
  a_r9_no_underflow_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SO_FOLD) |-> (count >= CW'(2)));
  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SO_PUSH) |=> (count == $past(count) + CW'(1)));
  a_r4_push_lands_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SO_PUSH) |=> (top == $past(wdata)));
endmodule

// File: rtl/smc_core.sv
`timescale 1ns/1ps
module smc_core
  import smc_pkg::*;
#(
  parameter int             DW       = 32,
  parameter int             AW       = 24,
  parameter int             DEPTH    = 16,
  parameter logic [AW-1:0]  RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic          mem_req_word,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          halted,
  output logic          fault
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int ABYTES = AW / 8;
  localparam int BIW    = $clog2(ABYTES + 1);
  localparam int LONG   = ABYTES + 1;

  state_t         state;
  logic [AW-1:0]  pc;
  logic [7:0]     opc_q;
  logic [AW-1:0]  addr_q;
  logic [BIW-1:0] bidx;
  logic           fault_q;

  logic [7:0]     rsp_byte, dec_in;
  kind_t          kind;
  alu_t           alu_sel;
  logic           long_form;
  logic [1:0]     need;
  logic           enough;

  stk_op_t        stk_op;
  logic [DW-1:0]  stk_wdata, top, second, alu_res;
  logic [CW-1:0]  count;
  logic           full;

  assign rsp_byte = mem_rsp_data[7:0];
  assign dec_in   = (state == S_IWAIT) ? rsp_byte : opc_q;

  smc_decode u_dec (
    .opc       (dec_in),
    .kind      (kind),
    .alu_sel   (alu_sel),
    .long_form (long_form),
    .need      (need)
  );

  smc_alu #(.W(DW)) u_alu (
    .lhs (second),
    .rhs (top),
    .sel (alu_sel),
    .res (alu_res)
  );

  smc_stack #(.W(DW), .DEPTH(DEPTH)) u_stk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (stk_op),
    .wdata  (stk_wdata),
    .top    (top),
    .second (second),
    .count  (count),
    .full   (full)
  );

  assign enough = (count >= CW'(need));

  always_comb begin
    stk_op = SO_NONE;
    case (state)
      S_EXEC:  if (kind == K_ALU && enough) stk_op = SO_FOLD;
      S_DREQ:  if (mem_req_ready && kind == K_POP) stk_op = SO_POP;
      S_DWAIT: if (mem_rsp_valid) stk_op = SO_PUSH;
      default: stk_op = SO_NONE;
    endcase
  end
  assign stk_wdata = (state == S_DWAIT) ? mem_rsp_data : alu_res;

  assign mem_req_valid = (state == S_IREQ) || (state == S_DREQ);
  assign mem_req_word  = (state == S_DREQ);
  assign mem_req_write = (state == S_DREQ) && (kind == K_POP);
  assign mem_req_addr  = (state == S_DREQ) ? addr_q : (pc + AW'(bidx));
  assign mem_req_wdata = mem_req_write ? top : '0;
  assign halted        = (state == S_HALT);
  assign fault         = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IREQ;
      pc      <= RESET_PC;
      opc_q   <= '0;
      addr_q  <= '0;
      bidx    <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IREQ: if (mem_req_ready) state <= S_IWAIT;
        S_IWAIT: if (mem_rsp_valid) begin
          if (bidx == '0) begin
            opc_q <= rsp_byte;
            if (long_form) begin
              bidx  <= BIW'(1);
              state <= S_IREQ;
            end else begin
              state <= S_EXEC;
            end
          end else begin
            addr_q <= {addr_q[AW-9:0], rsp_byte};
            if (bidx == BIW'(ABYTES)) begin
              bidx  <= '0;
              state <= S_EXEC;
            end else begin
              bidx  <= bidx + BIW'(1);
              state <= S_IREQ;
            end
          end
        end
        S_EXEC: begin
          case (kind)
            K_PUSH: begin
              if (full) begin fault_q <= 1'b1; state <= S_HALT; end
              else state <= S_DREQ;
            end
            K_POP: begin
              if (!enough) begin fault_q <= 1'b1; state <= S_HALT; end
              else state <= S_DREQ;
            end
            K_ALU: begin
              if (!enough) begin fault_q <= 1'b1; state <= S_HALT; end
              else begin pc <= pc + AW'(1); state <= S_IREQ; end
            end
            K_HALT: state <= S_HALT;
            default: begin fault_q <= 1'b1; state <= S_HALT; end
          endcase
        end
        S_DREQ: if (mem_req_ready) begin
          if (kind == K_POP) begin
            pc    <= pc + AW'(LONG);
            state <= S_IREQ;
          end else begin
            state <= S_DWAIT;
          end
        end
        S_DWAIT: if (mem_rsp_valid) begin
          pc    <= pc + AW'(LONG);
          state <= S_IREQ;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_word) && $stable(mem_req_wdata)));
  a_r11_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state == S_IWAIT || state == S_DWAIT));
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(fault)));
  a_r12_fault_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);
  a_r2_pc_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DWAIT && mem_rsp_valid) |=>
      (mem_req_valid && !mem_req_word && mem_req_addr == $past(pc) + AW'(LONG)));
endmodule

// File: tb/smc_core_tb_top.sv
`timescale 1ns/1ps
module smc_core_tb_top;
  import smc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_write, req_word;
  logic        req_ready = 1'b0;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        halted, fault;

  always #2 clk = ~clk;

  smc_core dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (req_valid),
    .mem_req_ready (req_ready),
    .mem_req_write (req_write),
    .mem_req_word  (req_word),
    .mem_req_addr  (req_addr),
    .mem_req_wdata (req_wdata),
    .mem_rsp_valid (rsp_valid),
    .mem_rsp_data  (rsp_data),
    .halted        (halted),
    .fault         (fault)
  );

  logic [7:0] mem [0:4095];
  int checks = 0, errors = 0;
  int n_byte_rd = 0, n_word_rd = 0, n_word_wr = 0, n_stall = 0, n_viol = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'hA5;
  bit pend = 0, prev_st = 0;
  logic [31:0] pend_data, p_wd;
  logic [23:0] p_addr;
  logic p_wr, p_word;
  int pp;

  function automatic logic [31:0] rdw(input int a);
    return {mem[a & 4095], mem[(a + 1) & 4095], mem[(a + 2) & 4095], mem[(a + 3) & 4095]};
  endfunction

  task automatic wrw(input int a, input logic [31:0] v);
    mem[a & 4095] = v[31:24];
    mem[(a + 1) & 4095] = v[23:16];
    mem[(a + 2) & 4095] = v[15:8];
    mem[(a + 3) & 4095] = v[7:0];
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    pp = 0;
  endtask

  task automatic emit1(input logic [7:0] b);
    mem[pp] = b;
    pp++;
  endtask

  task automatic emit4(input logic [7:0] op, input int a);
    emit1(op);
    emit1(a[23:16]);
    emit1(a[15:8]);
    emit1(a[7:0]);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: drives at the falling edge only
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      pend = 0; rsp_valid = 0; prev_st = 0; req_ready = 0;
    end else begin
      if (prev_st) begin
        if (!(req_valid && req_addr == p_addr && req_write == p_wr &&
              req_word == p_word && req_wdata == p_wd)) n_viol++;
      end
      if (pend) begin rsp_valid = 1; rsp_data = pend_data; pend = 0; end
      else rsp_valid = 0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready = !stall_en || (lfsr[1:0] != 2'b00);
      prev_st = 0;
      if (req_valid && req_ready) begin
        if (req_write) begin wrw(int'(req_addr[11:0]), req_wdata); n_word_wr++; end
        else if (req_word) begin pend = 1; pend_data = rdw(int'(req_addr[11:0])); n_word_rd++; end
        else begin pend = 1; pend_data = {24'h0, mem[req_addr[11:0]]}; n_byte_rd++; end
      end else if (req_valid) begin
        prev_st = 1; n_stall++;
        p_addr = req_addr; p_wr = req_write; p_word = req_word; p_wd = req_wdata;
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    n_byte_rd = 0; n_word_rd = 0; n_word_wr = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
  endtask

  task automatic run(input int limit);
    do_reset();
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      #1;
      if (halted) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] vals [6];
  initial begin
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7;
    vals[3] = 32'h7FFFFFFF; vals[4] = 32'h80000000; vals[5] = 32'hFFFFFFFF;
    clear_mem();

    // R1: state right after reset release
    do_reset();
    #1;
    chk(req_valid && !req_word && !req_write && req_addr == 24'h0, "R1", "first fetch",
        {6'h0, req_valid, req_word, req_addr}, {6'h0, 2'b10, 24'h0});
    chk(!halted && !fault, "R1", "flags after reset", {30'h0, halted, fault}, 32'h0);

    // R5 R6 R7 R2 R11: operand sweep for each arithmetic opcode
    for (int ia = 0; ia < 6; ia++) begin
      for (int ib = 0; ib < 6; ib++) begin
        for (int k = 0; k < 3; k++) begin
          logic [31:0] a, b, exp;
          logic [7:0] op;
          string tag;
          a = vals[ia]; b = vals[ib];
          case (k)
            0: begin op = OPC_ADD; exp = a + b; tag = "R5"; end
            1: begin op = OPC_SUB; exp = a - b; tag = "R6"; end
            default: begin op = OPC_MUL; exp = a * b; tag = "R7"; end
          endcase
          clear_mem();
          emit4(OPC_PUSH, 'h400); emit4(OPC_PUSH, 'h404); emit1(op);
          emit4(OPC_POP, 'h408); emit1(OPC_HALT);
          wrw('h400, a); wrw('h404, b);
          stall_en = ((ia + ib + k) % 2) == 1;
          run(600);
          chk(rdw('h408) == exp, tag, "arith result", rdw('h408), exp);
          chk(halted && !fault && n_byte_rd == 14 && n_word_rd == 2 && n_word_wr == 1,
              "R2", "fetch and access counts", n_byte_rd, 14);
        end
      end
    end

    // R4 R3: LIFO order at every depth, R8 boundary at 16
    for (int n = 1; n <= 16; n++) begin
      bit ok;
      int bad;
      clear_mem();
      stall_en = (n % 3) == 0;
      for (int i = 0; i < n; i++) begin
        emit4(OPC_PUSH, 'h400 + 4 * i);
        wrw('h400 + 4 * i, 32'hC0DE0000 + 32'(i * 257));
      end
      for (int j = 0; j < n; j++) emit4(OPC_POP, 'h600 + 4 * j);
      emit1(OPC_HALT);
      run(3000);
      ok = 1; bad = 0;
      for (int j = 0; j < n; j++)
        if (rdw('h600 + 4 * j) != 32'hC0DE0000 + 32'(((n - 1 - j) * 257))) begin ok = 0; bad = j; end
      chk(ok && halted && !fault && n_word_rd == n, "R4", "stored order",
          rdw('h600 + 4 * bad), 32'hC0DE0000 + 32'(((n - 1 - bad) * 257)));
    end

    // R8: seventeenth load faults without a read
    clear_mem();
    stall_en = 1;
    for (int i = 0; i < 17; i++) emit4(OPC_PUSH, 'h400);
    emit1(OPC_HALT);
    run(3000);
    chk(halted && fault, "R8", "overflow flags", {30'h0, halted, fault}, 32'h3);
    chk(n_word_rd == 16 && n_byte_rd == 68, "R8", "reads before overflow", n_word_rd, 16);

    // R9: store on empty stack
    clear_mem();
    stall_en = 0;
    emit4(OPC_POP, 'h700); emit1(OPC_HALT);
    wrw('h700, 32'h5A5A5A5A);
    run(500);
    chk(halted && fault && n_word_wr == 0 && n_byte_rd == 4, "R9", "empty store",
        n_word_wr, 0);
    chk(rdw('h700) == 32'h5A5A5A5A, "R9", "memory untouched", rdw('h700), 32'h5A5A5A5A);

    // R9: subtract with one entry
    clear_mem();
    stall_en = 1;
    emit4(OPC_PUSH, 'h400); emit1(OPC_SUB); emit4(OPC_POP, 'h700); emit1(OPC_HALT);
    wrw('h400, 32'h11); wrw('h700, 32'h22);
    run(500);
    chk(halted && fault && n_word_wr == 0 && n_byte_rd == 5 && rdw('h700) == 32'h22,
        "R9", "short arithmetic", n_byte_rd, 5);

    // R10 R12: clean stop stays stopped and quiet
    clear_mem();
    stall_en = 0;
    emit1(OPC_HALT);
    run(200);
    chk(halted && !fault && n_byte_rd == 1, "R10", "stop opcode", {30'h0, halted, fault}, 32'h2);
    repeat (20) @(negedge clk);
    #1;
    chk(halted && !fault && n_byte_rd == 1 && n_word_rd == 0 && n_word_wr == 0,
        "R12", "halt is sticky and silent", n_byte_rd, 1);

    // R10 R12: unknown opcode
    clear_mem();
    emit1(8'h55);
    run(200);
    chk(halted && fault && n_byte_rd == 1, "R10", "unknown opcode", {30'h0, halted, fault}, 32'h3);
    repeat (20) @(negedge clk);
    #1;
    chk(halted && fault, "R12", "fault is sticky", {30'h0, halted, fault}, 32'h3);

    // R1: reset clears the fault
    do_reset();
    #1;
    chk(!halted && !fault && req_valid && req_addr == 24'h0, "R1", "reset after fault",
        {30'h0, halted, fault}, 32'h0);

    // R5 R6 R7 R2: mixed program ((a-b)*c)+d under back-pressure
    begin
      logic [31:0] a, b, c, d, exp;
      a = 32'h12345678; b = 32'h00000078; c = 32'h00010003; d = 32'hFFFFFFF0;
      exp = ((a - b) * c) + d;
      clear_mem();
      stall_en = 1;
      emit4(OPC_PUSH, 'h400); emit4(OPC_PUSH, 'h404); emit1(OPC_SUB);
      emit4(OPC_PUSH, 'h408); emit1(OPC_MUL); emit4(OPC_PUSH, 'h40C); emit1(OPC_ADD);
      emit4(OPC_POP, 'h500); emit1(OPC_HALT);
      wrw('h400, a); wrw('h404, b); wrw('h408, c); wrw('h40C, d);
      run(1000);
      chk(rdw('h500) == exp, "R5", "mixed expression", rdw('h500), exp);
      chk(halted && !fault && n_byte_rd == 24, "R2", "mixed lengths", n_byte_rd, 24);
    end

    // R11: stalled requests never changed
    chk(n_viol == 0 && n_stall > 0, "R11", "request held under stall", n_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule